// File: doc/BRIEF.md
# Swallow Counter with Modulus Flag

This block is the swallow stage of a pulse-swallow integer-N divider. It holds a programmable 6-bit down counter that advances once per prescaler period, signalled by a one-cycle strobe. After a load the counter starts from the programmed swallow value S, and the modulus flag stays low. While the flag is low, the prescaler divides by its larger ratio. When the counter has consumed S prescaler periods, the flag goes high and the prescaler switches to its smaller ratio for the rest of the output cycle.

While the flag is high, the counter does nothing at all: strobes are ignored and the register holds still, which saves switching power. Only a load pulse from the program counter leaves this state. The load reloads S and drops the flag. The programmed value is limited according to the band select: the low band allows values up to 31, and the high band allows values up to 47. A value of zero raises the flag on the cycle that follows the load, so the smaller ratio is used for the whole output cycle.

Top module: `swallow_cnt`

## Requirements
- R1: While rst_ni is low, and on the first sampled cycle after it goes high, mod_o is 0.
- R2: A clock edge with load_i high and a nonzero effective value (see R8 and R9) leaves mod_o at 0 after that edge.
- R3: After a load of effective value S greater than 0, mod_o rises at the clock edge that sees the S-th cycle with tick_i high. Before that edge it stays 0.
- R4: Clock edges with tick_i low and load_i low leave mod_o unchanged and do not advance the count.
- R5: Once mod_o is 1, it stays 1 through any number of tick_i strobes until a load. No tick is counted while it is high.
- R6: load_i takes priority over tick_i in the same cycle. The count restarts from the new value, that tick is not counted, and a high mod_o is cleared.
- R7: A load with effective value 0 sets mod_o to 1 at the load edge.
- R8: With band_hi_i = 0 (low band), the effective value is prog_i limited to 31. For example, 40 behaves as 31.
- R9: With band_hi_i = 1 (high band), the effective value is prog_i limited to 47. For example, 63 behaves as 47 and 40 stays 40. The band is sampled on the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler period strobe, one cycle per prescaler period |
| load_i | input | 1 | Reload pulse from the program counter |
| prog_i | input | 6 | Programmed swallow value S |
| band_hi_i | input | 1 | Band select: 0 for the low band (limit 31), 1 for the high band (limit 47) |
| mod_o | output | 1 | Modulus flag: 0 selects the larger prescaler ratio, 1 selects the smaller |

## Verification
The load pulse and the period strobe can arrive in the same cycle. The bench provokes this in two ways. First, it raises both while the count is still running. Second, it raises both while the flag is high. In each case the count must restart from the new value without counting that tick, so the bench counts the strobes needed afterwards until the flag rises again. The flag must also stay low on the edges in between, which shows that the coincident tick was neither counted nor allowed to set the flag.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned LO_MAX = 31;
  localparam int unsigned HI_MAX = 47;
endpackage

// File: rtl/swc_limit.sv
module swc_limit #(
  parameter int unsigned W      = 6,
  parameter int unsigned LO_MAX = 31,
  parameter int unsigned HI_MAX = 47
) (
  input  logic [W-1:0] prog_i,
  input  logic         band_hi_i,
  output logic [W-1:0] lim_o,
  output logic         zero_o
);
  localparam logic [W-1:0] LoCap = W'(LO_MAX);
  localparam logic [W-1:0] HiCap = W'(HI_MAX);

  logic [W-1:0] cap;
  assign cap    = band_hi_i ? HiCap : LoCap;
  assign lim_o  = (prog_i > cap) ? cap : prog_i;
  assign zero_o = (lim_o == '0);
endmodule

// File: rtl/swc_down.sv
module swc_down #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] lim_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] One = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= lim_i;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q - One;
  end

  // this step ends the count
  assign last_o = (cnt_q <= One);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/swc_flag.sv
module swc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_zero_i,
  input  logic set_i,
  output logic mod_o
);
  logic mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mod_q <= 1'b0;
    else if (load_i) mod_q <= load_zero_i;
    else if (set_i)  mod_q <= 1'b1;
  end

  assign mod_o = mod_q;
endmodule

// File: rtl/swallow_cnt.sv
module swallow_cnt
  import swc_pkg::*;
#(
  parameter int unsigned W      = CNT_W,
  parameter int unsigned LO_LIM = LO_MAX,
  parameter int unsigned HI_LIM = HI_MAX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] prog_i,
  input  logic         band_hi_i,
  output logic         mod_o
);
  logic [W-1:0] lim;
  logic         lim_zero;
  logic [W-1:0] cnt_q;
  logic         last;
  logic         step;
  logic         mod_q;

  swc_limit #(.W(W), .LO_MAX(LO_LIM), .HI_MAX(HI_LIM)) u_limit (
    .prog_i    (prog_i),
    .band_hi_i (band_hi_i),
    .lim_o     (lim),
    .zero_o    (lim_zero)
  );

  // frozen while flag is high
  assign step = tick_i & ~mod_q;

  swc_down #(.W(W)) u_down (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .lim_i  (lim),
    .step_i (step),
    .cnt_o  (cnt_q),
    .last_o (last)
  );

  swc_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_zero_i (lim_zero),
    .set_i       (step & last),
    .mod_o       (mod_q)
  );

  assign mod_o = mod_q;
endmodule

// File: rtl/swallow_cnt_chk.sv
module swallow_cnt_chk #(
  parameter int unsigned W      = 6,
  parameter int unsigned LO_LIM = 31,
  parameter int unsigned HI_LIM = 47
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         load_i,
  input logic         band_hi_i,
  input logic [W-1:0] prog_i,
  input logic [W-1:0] cnt,
  input logic         mod_o
);
  localparam logic [W-1:0] LoCap = W'(LO_LIM);
  localparam logic [W-1:0] HiCap = W'(HI_LIM);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |=> !mod_o);

  // R2
  load_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && prog_i != '0 |=> !mod_o);

  // R3
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_o) |-> ($past(load_i) && $past(prog_i) == '0) ||
                     ($past(tick_i) && $past(cnt) <= W'(1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt) && $stable(mod_o));

  // R5
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o && !load_i |=> mod_o && $stable(cnt));

  // R6
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && tick_i && prog_i > W'(1) |=> !mod_o && cnt > W'(1));

  // R7
  zero_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && prog_i == '0 |=> mod_o);

  // R8
  lo_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !band_hi_i |=> cnt <= LoCap);

  // R9
  hi_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && band_hi_i |=> cnt <= HiCap);
endmodule

bind swallow_cnt swallow_cnt_chk #(.W(W), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .load_i    (load_i),
  .band_hi_i (band_hi_i),
  .prog_i    (prog_i),
  .cnt       (cnt_q),
  .mod_o     (mod_o)
);

// File: tb/swallow_cnt_tb.sv
`timescale 1ns/1ps
module swallow_cnt_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       load_i = 1'b0;
  logic [5:0] prog_i = '0;
  logic       band_hi_i = 1'b0;
  logic       mod_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  swallow_cnt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(load_i),
    .prog_i(prog_i), .band_hi_i(band_hi_i), .mod_o(mod_o)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: mod_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // called at a negedge; applies inputs over one posedge, returns at next negedge
  task automatic cyc(input logic t, input logic l);
    tick_i = t; load_i = l;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0; load_i = 1'b0;
  endtask

  task automatic do_load(input logic [5:0] v, input logic band, input logic t);
    prog_i = v; band_hi_i = band;
    cyc(t, 1'b1);
    band_hi_i = ~band;   // band must not matter after load (R9)
    prog_i = 6'd1;
  endtask

  task automatic t_reset;
    chk(mod_o, 1'b0, "R1 during reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mod_o, 1'b0, "R1 after reset");
  endtask

  // load v, expect flag after exp_n ticks; idle gaps between ticks
  task automatic t_count(input logic [5:0] v, input logic band, input int exp_n,
                         input string req);
    do_load(v, band, 1'b0);
    chk(mod_o, 1'b0, "R2 low after load");
    for (int i = 1; i <= exp_n; i++) begin
      if (i % 3 == 0) begin
        cyc(1'b0, 1'b0);
        chk(mod_o, 1'b0, "R4 idle cycle no advance");
      end
      cyc(1'b1, 1'b0);
      chk(mod_o, (i == exp_n), req);
    end
  endtask

  task automatic t_hold;
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b0);
      chk(mod_o, 1'b1, "R5 flag holds under ticks");
    end
    cyc(1'b0, 1'b0);
    chk(mod_o, 1'b1, "R4 R5 flag holds when idle");
  endtask

  task automatic t_zero;
    do_load(6'd0, 1'b0, 1'b0);
    chk(mod_o, 1'b1, "R7 zero load sets flag");
    cyc(1'b1, 1'b0);
    chk(mod_o, 1'b1, "R7 R5 stays high");
  endtask

  task automatic t_collide;
    // flag high, load + tick together
    do_load(6'd3, 1'b0, 1'b1);
    chk(mod_o, 1'b0, "R6 load clears high flag");
    for (int i = 1; i <= 3; i++) begin
      cyc(1'b1, 1'b0);
      chk(mod_o, (i == 3), "R6 coincident tick not counted");
    end
    // mid-count reload with tick
    do_load(6'd5, 1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    chk(mod_o, 1'b0, "R3 mid count");
    do_load(6'd2, 1'b1, 1'b1);
    chk(mod_o, 1'b0, "R6 reload mid count");
    cyc(1'b1, 1'b0);
    chk(mod_o, 1'b0, "R6 restart count 1");
    cyc(1'b1, 1'b0);
    chk(mod_o, 1'b1, "R6 restart count 2");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_count(6'd1, 1'b0, 1, "R3 S=1");
    t_hold();
    t_count(6'd7, 1'b0, 7, "R3 S=7");
    t_hold();
    t_zero();
    t_collide();
    t_count(6'd40, 1'b0, 31, "R8 low band 40 capped to 31");
    t_count(6'd31, 1'b0, 31, "R8 low band 31 kept");
    t_count(6'd63, 1'b1, 47, "R9 high band 63 capped to 47");
    t_count(6'd40, 1'b1, 40, "R9 high band 40 kept");
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule